// File: doc/BRIEF.md
# I2C Target Engine with 7/10-bit and General-Call Addressing

This block is the bus-side engine of an I2C target. It resynchronizes the SCL and SDA lines into the system clock, finds START and STOP conditions, and shifts bytes most significant bit first. The first byte after a START is compared against a programmable own address. That address is matched either in its 7-bit form or in its 10-bit form, which uses a header byte plus a low-address byte. When enabled, the all-zero general call is also recognized. The engine drives the acknowledge on the ninth clock and, for a read, serves bytes taken from its transmit-data input.

SDA is never driven high. The block only pulls it low, through `sda_oe`, and the pad or the bench forms the wired-AND with the other bus agents. A byte-wide set of ports holds the received byte, a strobe for each byte, a strobe when a transmit byte is taken, and the status flags for address hit, read direction, general call and STOP seen. The address mode, the general-call enable and the acknowledge enable are static inputs, and each may be changed between transfers.

Top module: `i2c_tgt_core`

## Requirements
- R1: A STOP (SDA rising while SCL is high) raises `stop_det` for exactly one clock and clears `addr_hit`, `is_read` and `gen_call`. A START (SDA falling while SCL is high) also clears those three flags and begins a new address phase.
- R2: In a write, each byte is shifted in MSB first. When the ninth clock begins, the byte appears on `rx_data` with a one-clock `rx_valid` pulse.
- R3: With `cfg_addr10`=0, a first byte whose bits [7:1] equal `cfg_own_addr[6:0]` is acknowledged (SDA low during the ninth clock) and sets `addr_hit`. Bit 0 set to 1 means read.
- R4: With `cfg_addr10`=1, a header 11110 followed by `cfg_own_addr[9:8]` and R/W=0 is acknowledged. The next byte is acknowledged and sets `addr_hit` only if it equals `cfg_own_addr[7:0]`.
- R5: With `cfg_gc_en`=1, a first byte of 0x00 is acknowledged and sets `addr_hit` and `gen_call`. With `cfg_gc_en`=0 it is not acknowledged unless it matches the own address.
- R6: With `cfg_ack_en`=0, SDA stays released on every ninth clock of a received byte. Address matching still sets `addr_hit`, and data is still captured.
- R7: In a read, each byte of `tx_data` is latched on the SCL fall that ends the preceding ninth clock (with a one-clock `tx_load` pulse) and is sent MSB first. A master NACK ends the transmit, and SDA stays released.
- R8: A repeated START restarts address matching without a STOP. After a complete 10-bit write match, a header 11110+`cfg_own_addr[9:8]`+R/W=1 following a repeated START is acknowledged as a read. Once a STOP has been seen, that header alone is not acknowledged.
- R9: A target that is not addressed never drives SDA until the next START.
- R10: After reset, `sda_oe`, all strobes and all flags are 0, and `rx_data` is 0.
- R11: `cfg_addr10` selects which address form is matched. In 10-bit mode a 7-bit header for the low address is ignored, and in 7-bit mode only `cfg_own_addr[6:0]` is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| cfg_own_addr | input | 10 | Own address; low 7 bits used in 7-bit mode |
| cfg_addr10 | input | 1 | 1 = match 10-bit form, 0 = 7-bit form |
| cfg_gc_en | input | 1 | Enable general call recognition |
| cfg_ack_en | input | 1 | Enable driving acknowledge |
| tx_data | input | 8 | Byte to send in a read |
| tx_load | output | 1 | One-clock pulse when tx_data is latched |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock pulse when rx_data updates |
| addr_hit | output | 1 | Currently addressed |
| is_read | output | 1 | Addressed for a read |
| gen_call | output | 1 | Addressed by general call |
| stop_det | output | 1 | One-clock pulse on STOP |

## Verification
The bench targets the points where address decoding can go wrong. A 10-bit header that matches but is followed by the wrong low byte must give no acknowledge on that byte and must leave the data phase unacknowledged. A design that accepts on the header alone would acknowledge both. The general-call byte is tested with the enable both on and off, and mode switching is tested with headers that would match only in the other mode. The read path is tested across a master ACK followed by a NACK, and across a repeated START into a 10-bit read. A design that loses its armed state there would fail to acknowledge, and one that keeps it past a STOP would acknowledge a bare read header.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int OWN_W  = 10;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [4:0]        HDR10_TAG = 5'b11110;
  localparam logic [BYTE_W-1:0] GC_BYTE   = 8'h00;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_ADR2,
    PH_WR,
    PH_RD,
    PH_IGN
  } phase_t;

  typedef enum logic [2:0] {
    HK_NONE,
    HK_OWN7,
    HK_GC,
    HK_T10W,
    HK_T10R
  } hdr_kind_t;
endpackage

// File: rtl/i2c_tgt_lsync.sv
module i2c_tgt_lsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_amatch.sv
module i2c_tgt_amatch
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [OWN_W-1:0]  own,
  input  logic              addr10,
  input  logic              gc_en,
  input  logic              armed,
  output hdr_kind_t         kind,
  output logic              lo_ok
);
  logic rw;
  assign rw    = byte_in[0];
  assign lo_ok = (byte_in == own[7:0]);

  always_comb begin
    kind = HK_NONE;
    if (gc_en && byte_in == GC_BYTE) begin
      kind = HK_GC;
    end else if (addr10) begin
      if (byte_in[7:3] == HDR10_TAG && byte_in[2:1] == own[9:8]) begin
        if (!rw)       kind = HK_T10W;
        else if (armed) kind = HK_T10R;
      end
    end else if (byte_in[7:1] == own[6:0]) begin
      kind = HK_OWN7;
    end
  end
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [OWN_W-1:0]  cfg_own_addr,
  input  logic              cfg_addr10,
  input  logic              cfg_gc_en,
  input  logic              cfg_ack_en,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addr_hit,
  output logic              is_read,
  output logic              gen_call,
  output logic              stop_det
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              own_ack, ten_armed;
  hdr_kind_t         kind;
  logic              lo_ok, rx_phase;

  i2c_tgt_lsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  i2c_tgt_amatch u_match (
    .byte_in(shreg), .own(cfg_own_addr), .addr10(cfg_addr10),
    .gc_en(cfg_gc_en), .armed(ten_armed), .kind(kind), .lo_ok(lo_ok)
  );

  assign rx_phase = (phase == PH_HDR) || (phase == PH_ADR2) || (phase == PH_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      own_ack   <= 1'b0;
      ten_armed <= 1'b0;
      sda_oe    <= 1'b0;
      tx_load   <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      addr_hit  <= 1'b0;
      is_read   <= 1'b0;
      gen_call  <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      stop_det <= 1'b0;
      if (stop_c) begin
        phase     <= PH_IDLE;
        sda_oe    <= 1'b0;
        own_ack   <= 1'b0;
        ten_armed <= 1'b0;
        addr_hit  <= 1'b0;
        is_read   <= 1'b0;
        gen_call  <= 1'b0;
        stop_det  <= 1'b1;
      end else if (start_c) begin
        phase    <= PH_HDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        own_ack  <= 1'b0;
        addr_hit <= 1'b0;
        is_read  <= 1'b0;
        gen_call <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == LAST_BIT) begin
            bitcnt  <= '0;
            own_ack <= 1'b0;
            if (phase == PH_RD && !own_ack && sda_s) phase <= PH_IGN;
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
            if (rx_phase) shreg <= {shreg[BYTE_W-2:0], sda_s};
          end
        end else if (scl_fall) begin
          if (bitcnt == LAST_BIT) begin
            unique case (phase)
              PH_HDR: begin
                unique case (kind)
                  HK_OWN7: begin
                    addr_hit <= 1'b1;
                    is_read  <= shreg[0];
                    phase    <= shreg[0] ? PH_RD : PH_WR;
                    sda_oe   <= cfg_ack_en;
                    own_ack  <= 1'b1;
                  end
                  HK_GC: begin
                    addr_hit <= 1'b1;
                    gen_call <= 1'b1;
                    phase    <= PH_WR;
                    sda_oe   <= cfg_ack_en;
                    own_ack  <= 1'b1;
                  end
                  HK_T10W: begin
                    phase   <= PH_ADR2;
                    sda_oe  <= cfg_ack_en;
                    own_ack <= 1'b1;
                  end
                  HK_T10R: begin
                    addr_hit <= 1'b1;
                    is_read  <= 1'b1;
                    phase    <= PH_RD;
                    sda_oe   <= cfg_ack_en;
                    own_ack  <= 1'b1;
                  end
                  default: begin
                    phase  <= PH_IGN;
                    sda_oe <= 1'b0;
                  end
                endcase
              end
              PH_ADR2: begin
                if (lo_ok) begin
                  addr_hit  <= 1'b1;
                  ten_armed <= 1'b1;
                  phase     <= PH_WR;
                  sda_oe    <= cfg_ack_en;
                  own_ack   <= 1'b1;
                end else begin
                  phase  <= PH_IGN;
                  sda_oe <= 1'b0;
                end
              end
              PH_WR: begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
                sda_oe   <= cfg_ack_en;
                own_ack  <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == '0) begin
            if (phase == PH_RD) begin
              txsh    <= tx_data;
              sda_oe  <= ~tx_data[BYTE_W-1];
              tx_load <= 1'b1;
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (phase == PH_RD) begin
            sda_oe <= ~txsh[~bitcnt[2:0]];
          end
        end
      end
    end
  end

  // R9: an idle or unaddressed target keeps SDA released
  p_quiet_unaddr_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGN || phase == PH_IDLE) |-> !sda_oe);

  // R1: a STOP seen by the line detector releases SDA and clears status
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> (!sda_oe && !addr_hit && stop_det));

  p_stop_single_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stop_det);

  // R2: one strobe per received byte
  p_rx_single_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: outside a read, a new pull-low needs acknowledge enabled
  p_ack_gate_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && phase != PH_RD) |-> $past(cfg_ack_en));

  // R7: transmit bytes are only taken while addressed for read
  p_tx_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (is_read && addr_hit));

  // R5: general call is a write only
  p_gc_write_r5: assert property (@(posedge clk) disable iff (rst)
    gen_call |-> !is_read);
endmodule

// File: tb/tb_i2c_tgt_core.sv
module tb_i2c_tgt_core;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [9:0] cfg_own_addr = '0;
  logic cfg_addr10 = 1'b0, cfg_gc_en = 1'b0, cfg_ack_en = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_load, rx_valid, addr_hit, is_read, gen_call, stop_det;
  logic [7:0] rx_data;

  int checks = 0, failures = 0;
  int n_stop = 0, n_rx = 0, n_tx = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tgt_core dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .cfg_own_addr(cfg_own_addr), .cfg_addr10(cfg_addr10), .cfg_gc_en(cfg_gc_en),
    .cfg_ack_en(cfg_ack_en), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_valid(rx_valid), .addr_hit(addr_hit),
    .is_read(is_read), .gen_call(gen_call), .stop_det(stop_det)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (stop_det) n_stop++;
      if (rx_valid) n_rx++;
      if (tx_load)  n_tx++;
    end
  end

  typedef struct packed {
    logic       a10;
    logic [9:0] own;
    logic       gc;
    logic       ack;
    logic [7:0] b0;
    logic [7:0] b1;
    logic       two;
    logic       e0;
    logic       e1;
    logic       ed;
    logic       ehit;
    logic       egc;
    logic [7:0] d;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 10'h03A, 1'b0, 1'b1, 8'h74, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC3},
    '{1'b0, 10'h03A, 1'b0, 1'b1, 8'h76, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
    '{1'b0, 10'h03A, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81},
    '{1'b0, 10'h03A, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
    '{1'b0, 10'h03A, 1'b0, 1'b0, 8'h74, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},
    '{1'b1, 10'h2A5, 1'b0, 1'b1, 8'hF4, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h96},
    '{1'b1, 10'h2A5, 1'b0, 1'b1, 8'hF4, 8'hA6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96},
    '{1'b1, 10'h2A5, 1'b0, 1'b1, 8'hF2, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96},
    '{1'b1, 10'h03A, 1'b0, 1'b1, 8'h74, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11},
    '{1'b0, 10'h2A5, 1'b0, 1'b1, 8'h4A, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hE7},
    '{1'b1, 10'h2A5, 1'b1, 1'b0, 8'hF4, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h42}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hw(H);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H/2);
    b = sda_line; hw(H/2);
    scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    acked = ~s;
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(s);
      v[i] = s;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    int s0, r0, t0;
    hw(5);
    rst = 1'b0;
    hw(2);
    // R10: reset state
    chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    chk({addr_hit, is_read, gen_call, stop_det, rx_valid, tx_load} == 6'b0, "R10 flags",
        {addr_hit, is_read, gen_call, stop_det, rx_valid, tx_load}, 0);
    chk(rx_data == 8'h00, "R10 rx_data", rx_data, 0);

    // Vector walk: R2 R3 R4 R5 R6 R9 R11
    for (int k = 0; k < 11; k++) begin
      cfg_addr10   = VEC[k].a10;
      cfg_own_addr = VEC[k].own;
      cfg_gc_en    = VEC[k].gc;
      cfg_ack_en   = VEC[k].ack;
      r0 = n_rx;
      s0 = n_stop;
      bus_start();
      put_byte(VEC[k].b0, a);
      chk(a == VEC[k].e0, $sformatf("R3/R4/R5/R6/R11 v%0d first ack", k), a, VEC[k].e0);
      if (VEC[k].two) begin
        put_byte(VEC[k].b1, a);
        chk(a == VEC[k].e1, $sformatf("R4 v%0d second ack", k), a, VEC[k].e1);
      end
      put_byte(VEC[k].d, a);
      chk(a == VEC[k].ed, $sformatf("R6/R9 v%0d data ack", k), a, VEC[k].ed);
      chk(addr_hit == VEC[k].ehit, $sformatf("R3/R4 v%0d addr_hit", k), addr_hit, VEC[k].ehit);
      chk(gen_call == VEC[k].egc, $sformatf("R5 v%0d gen_call", k), gen_call, VEC[k].egc);
      if (VEC[k].ehit) begin
        chk(rx_data == VEC[k].d, $sformatf("R2 v%0d rx_data", k), rx_data, VEC[k].d);
        chk(n_rx == r0 + 1, $sformatf("R2 v%0d rx_valid count", k), n_rx - r0, 1);
      end else begin
        chk(n_rx == r0, $sformatf("R9 v%0d no capture", k), n_rx - r0, 0);
      end
      bus_stop();
      chk(n_stop == s0 + 1, $sformatf("R1 v%0d stop pulse", k), n_stop - s0, 1);
      chk(addr_hit == 1'b0, $sformatf("R1 v%0d hit cleared", k), addr_hit, 0);
    end

    // R7: 7-bit read, ACK then NACK
    cfg_addr10 = 1'b0; cfg_own_addr = 10'h03A; cfg_gc_en = 1'b0; cfg_ack_en = 1'b1;
    tx_data = 8'hC6;
    t0 = n_tx;
    bus_start();
    put_byte(8'h75, a);
    chk(a == 1'b1, "R7 read addr ack", a, 1);
    chk(is_read == 1'b1, "R7 is_read", is_read, 1);
    get_byte(b);
    chk(b == 8'hC6, "R7 first byte", b, 8'hC6);
    tx_data = 8'h39;
    put_bit(1'b0);
    get_byte(b);
    chk(b == 8'h39, "R7 second byte", b, 8'h39);
    put_bit(1'b1);
    hw(H);
    chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    chk(n_tx == t0 + 2, "R7 tx_load count", n_tx - t0, 2);
    bus_stop();

    // R8: 7-bit write then repeated START into read
    tx_data = 8'hA7;
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h10, a);
    bus_start();
    chk(addr_hit == 1'b0, "R1 START clears hit", addr_hit, 0);
    put_byte(8'h75, a);
    chk(a == 1'b1 && is_read == 1'b1, "R8 restart read 7-bit", {a, is_read}, 2'b11);
    get_byte(b);
    chk(b == 8'hA7, "R8 restart read data", b, 8'hA7);
    put_bit(1'b1);
    bus_stop();

    // R8: 10-bit write, repeated START, 10-bit read header
    cfg_addr10 = 1'b1; cfg_own_addr = 10'h2A5; tx_data = 8'h6D;
    bus_start();
    put_byte(8'hF4, a);
    put_byte(8'hA5, a);
    chk(a == 1'b1, "R4 low byte ack", a, 1);
    bus_start();
    put_byte(8'hF5, a);
    chk(a == 1'b1 && is_read == 1'b1, "R8 10-bit read header", {a, is_read}, 2'b11);
    get_byte(b);
    chk(b == 8'h6D, "R8 10-bit read data", b, 8'h6D);
    put_bit(1'b1);
    bus_stop();

    // R8: after STOP, the read header alone is refused
    bus_start();
    put_byte(8'hF5, a);
    chk(a == 1'b0, "R8 bare read header refused", a, 0);
    chk(addr_hit == 1'b0, "R9 not addressed", addr_hit, 0);
    bus_stop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule